// File: doc/BRIEF.md
# Mask-Decoded Tuple Shuffle Filter

This block is one lane of a data shuffler. A lane takes a group of eight update tuples at a time. Each tuple has a destination-lane field and a payload. The lane keeps only the tuples addressed to its own fixed identifier and passes them downstream one per cycle. The whole group is accepted as one unit through a valid/ready handshake on the input side. It is held inside the lane until every wanted tuple has been handed over through a second valid/ready handshake on the output side.

The lane builds an eight-bit hit vector by comparing every destination field with its identifier. A decoder turns that vector into a hit count and a packed list of the slot numbers that hit. The emitter then steps through this list directly. As a result, a group with k hits occupies the output for exactly k cycles, and no cycle is spent on a slot that does not match. A group with no hits is absorbed in a single cycle and produces no output.

Top module: `tuple_lane_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, out_valid is 0 and in_ready is 1.
- R2: Tuple i occupies bits [i*DEST_W +: DEST_W] of in_dest and bits [i*PAYLOAD_W +: PAYLOAD_W] of in_data. Tuple i is selected exactly when its full DEST_W-bit destination equals LANE_ID. Destination codes of LANES or above never match, and only selected tuples appear on the output.
- R3: The selected tuples of a group leave in ascending slot order, and out_index gives the slot number (0 to 7) of the tuple on the output.
- R4: With out_ready held at 1, a group with k ≥ 1 hits produces output on k consecutive cycles. The first of these is the cycle right after the group is accepted.
- R5: A group with no hits is accepted, produces no output, and leaves in_ready at 1, so the next group can be accepted on the following cycle.
- R6: in_ready is 0 while an accepted group still has tuples to deliver. It returns to 1 in the cycle in which the last tuple is handed over, so the next group is accepted in that same cycle.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_index and out_data hold their values on the next cycle.
- R8: out_data equals the payload of the input slot named by out_index. This holds for any hit pattern, including all eight slots hitting and only slot 7 hitting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A tuple group is offered |
| in_ready | output | 1 | Lane can take a group this cycle |
| in_dest | input | 8*DEST_W | Destination fields, slot i at [i*DEST_W +: DEST_W] |
| in_data | input | 8*PAYLOAD_W | Payloads, slot i at [i*PAYLOAD_W +: PAYLOAD_W] |
| out_valid | output | 1 | A selected tuple is on the output |
| out_ready | input | 1 | Downstream takes the tuple |
| out_index | output | 3 | Slot number of the output tuple |
| out_data | output | PAYLOAD_W | Payload of the output tuple |

## Verification
The case that needs the most care is the cycle in which two things happen together: the last hit of a group is handed downstream, and the next group is loaded. Here the load must take priority over advancing the pointer.

The bench provokes this by offering groups back to back, with in_valid already high while the previous group is still draining. It mixes groups of eight hits, one hit, and no hits. For each case it compares the logged cycle of the final output handshake with the cycle of the next input handshake. It also checks that the first tuple of the new group follows in the very next cycle, with the right slot and payload.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
  localparam int GROUP = 8;
  localparam int IDX_W = $clog2(GROUP);
  localparam int CNT_W = $clog2(GROUP + 1);
  typedef logic [IDX_W-1:0] slot_t;
  typedef logic [CNT_W-1:0] count_t;
endpackage

// File: rtl/tlf_mask_gen.sv
module tlf_mask_gen
  import tlf_pkg::*;
#(
  parameter int DEST_W  = 4,
  parameter int LANE_ID = 0
) (
  input  logic [GROUP*DEST_W-1:0] dest_flat,
  output logic [GROUP-1:0]        hit_mask
);
  for (genvar g = 0; g < GROUP; g++) begin : g_cmp
    assign hit_mask[g] = (dest_flat[g*DEST_W +: DEST_W] == DEST_W'(LANE_ID));
  end
endmodule

// File: rtl/tlf_pos_decoder.sv
module tlf_pos_decoder
  import tlf_pkg::*;
(
  input  logic [GROUP-1:0]       hit_mask,
  output count_t                 hit_count,
  output logic [GROUP*IDX_W-1:0] pos_flat
);
  count_t run;

  // Packs set-bit indices, lowest index into the lowest field.
  always_comb begin
    run      = '0;
    pos_flat = '0;
    for (int i = 0; i < GROUP; i++) begin
      if (hit_mask[i]) begin
        pos_flat[run[IDX_W-1:0]*IDX_W +: IDX_W] = slot_t'(i);
        run = run + count_t'(1);
      end
    end
    hit_count = run;
  end
endmodule

// File: rtl/tlf_emit_ctrl.sv
module tlf_emit_ctrl
  import tlf_pkg::*;
#(
  parameter int PAYLOAD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  count_t                   load_cnt,
  input  logic [GROUP*IDX_W-1:0]   load_pos,
  input  logic [GROUP*PAYLOAD_W-1:0] load_data,
  input  logic                     out_ready,
  output logic                     out_valid,
  output slot_t                    out_index,
  output logic [PAYLOAD_W-1:0]     out_data,
  output logic                     last_beat
);
  logic   busy_q, busy_d;
  count_t ptr_q, ptr_d;
  count_t cnt_q, cnt_d;
  logic   ctl_en;

  slot_t                pos_q  [GROUP];
  logic [PAYLOAD_W-1:0] data_q [GROUP];

  assign last_beat = busy_q && ((ptr_q + count_t'(1)) == cnt_q);
  assign ctl_en    = load | (busy_q & out_ready);

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    if (load) begin
      busy_d = (load_cnt != '0);
      ptr_d  = '0;
      cnt_d  = load_cnt;
    end else if (busy_q && out_ready) begin
      if (last_beat) busy_d = 1'b0;
      else           ptr_d  = ptr_q + count_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      cnt_q  <= '0;
    end else if (ctl_en) begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar s = 0; s < GROUP; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load) begin
        pos_q[s]  <= load_pos[s*IDX_W +: IDX_W];
        data_q[s] <= load_data[s*PAYLOAD_W +: PAYLOAD_W];
      end
    end
  end

  assign out_valid = busy_q;
  assign out_index = pos_q[ptr_q[IDX_W-1:0]];
  assign out_data  = data_q[out_index];
endmodule

// File: rtl/tuple_lane_filter.sv
module tuple_lane_filter
  import tlf_pkg::*;
#(
  parameter int LANES     = 12,
  parameter int LANE_ID   = 0,
  parameter int PAYLOAD_W = 16,
  localparam int DEST_W   = $clog2(LANES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [GROUP*DEST_W-1:0]    in_dest,
  input  logic [GROUP*PAYLOAD_W-1:0] in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [IDX_W-1:0]           out_index,
  output logic [PAYLOAD_W-1:0]       out_data
);
  logic [GROUP-1:0]       hit_mask;
  count_t                 hit_count;
  logic [GROUP*IDX_W-1:0] pos_flat;
  logic                   last_beat;
  logic                   accept;

  tlf_mask_gen #(.DEST_W(DEST_W), .LANE_ID(LANE_ID)) u_mask (
    .dest_flat (in_dest),
    .hit_mask  (hit_mask)
  );

  tlf_pos_decoder u_dec (
    .hit_mask  (hit_mask),
    .hit_count (hit_count),
    .pos_flat  (pos_flat)
  );

  assign in_ready = !out_valid || (out_ready && last_beat);
  assign accept   = in_valid && in_ready;

  tlf_emit_ctrl #(.PAYLOAD_W(PAYLOAD_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_cnt  (hit_count),
    .load_pos  (pos_flat),
    .load_data (in_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_index (out_index),
    .out_data  (out_data),
    .last_beat (last_beat)
  );
endmodule

// File: rtl/tlf_checker.sv
module tlf_checker
  import tlf_pkg::*;
#(
  parameter int PAYLOAD_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [IDX_W-1:0]     out_index,
  input logic [PAYLOAD_W-1:0] out_data
);
  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> !out_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_index) && $stable(out_data));

  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_ready |=> out_valid && (out_index > $past(out_index)));

  assert_load_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && out_valid |-> out_ready);

  assert_idle_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind tuple_lane_filter tlf_checker #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_index (out_index),
  .out_data  (out_data)
);

// File: tb/tuple_lane_filter_bench.sv
module tuple_lane_filter_bench;
  localparam int DW = 4;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [8*DW-1:0] in_dest = '0;
  logic [8*PW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [2:0] out_index;
  logic [PW-1:0] out_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  int oc[$];
  int oi[$];
  int od[$];
  int ac[$];

  int g_dest[4][8];
  int g_tag[4];

  tuple_lane_filter #(.LANES(12), .LANE_ID(0), .PAYLOAD_W(PW)) u_tuple_lane_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_index(out_index), .out_data(out_data)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        oc.push_back(cyc);
        oi.push_back(int'(out_index));
        od.push_back(int'(out_data));
      end
      if (in_valid && in_ready) ac.push_back(cyc);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic int payload(input int tag, input int slot);
    return ((tag & 8'hff) << 8) | slot;
  endfunction

  // Starts and ends one time unit after a rising edge.
  task automatic push(input int g);
    bit hs;
    for (int i = 0; i < 8; i++) begin
      in_dest[i*DW +: DW] = DW'(g_dest[g][i]);
      in_data[i*PW +: PW] = PW'(payload(g_tag[g], i));
    end
    in_valid = 1'b1;
    forever begin
      @(negedge clk); hs = in_ready;
      @(posedge clk); #1;
      if (hs) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic clear_logs();
    oc.delete(); oi.delete(); od.delete(); ac.delete();
  endtask

  // Pushes n groups back to back with out_ready high and checks order, data and timing.
  task automatic run_batch(input int n);
    int ei[$]; int ed[$]; int ec[$];
    int acc; int k;
    clear_logs();
    for (int g = 0; g < n; g++) push(g);
    idle(14);
    chk(ac.size() == n, "R6 accepted group count", ac.size(), n);
    if (ac.size() == n) begin
      acc = ac[0];
      for (int g = 0; g < n; g++) begin
        k = 0;
        for (int i = 0; i < 8; i++) begin
          if (g_dest[g][i] == 0) begin
            ei.push_back(i);
            ed.push_back(payload(g_tag[g], i));
            ec.push_back(acc + 1 + k);
            k++;
          end
        end
        acc = acc + ((k == 0) ? 1 : k);
        if (g < n - 1) begin
          if (k == 0) chk(ac[g+1] == acc, "R5 accept after empty group", ac[g+1], acc);
          else        chk(ac[g+1] == acc, "R6 accept on last beat", ac[g+1], acc);
        end
      end
      chk(oc.size() == ei.size(), "R2 selected tuple count", oc.size(), ei.size());
      for (int j = 0; j < ei.size() && j < oc.size(); j++) begin
        chk(oi[j] == ei[j], "R3 slot order", oi[j], ei[j]);
        chk(od[j] == ed[j], "R8 payload", od[j], ed[j]);
        chk(oc[j] == ec[j], "R4 output cycle", oc[j], ec[j]);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;
  endtask

  // Destinations slot7..slot0 = 1,0,2,2,3,0,9,11: hits at slots 2 and 6.
  task automatic t_example();
    int d[8] = '{11, 9, 0, 3, 2, 2, 0, 1};
    for (int i = 0; i < 8; i++) g_dest[0][i] = d[i];
    g_tag[0] = 8'h11;
    run_batch(1);
    chk(oi.size() == 2, "R2 example hit count", oi.size(), 2);
  endtask

  // Full group, top-slot-only group, empty group, then slots 0 and 3.
  task automatic t_back_to_back();
    for (int i = 0; i < 8; i++) begin
      g_dest[0][i] = 0;
      g_dest[1][i] = (i == 7) ? 0 : 5;
      g_dest[2][i] = 7;
      g_dest[3][i] = (i == 0 || i == 3) ? 0 : 2;
    end
    g_tag[0] = 8'h21; g_tag[1] = 8'h22; g_tag[2] = 8'h23; g_tag[3] = 8'h24;
    run_batch(4);
  endtask

  // Codes 8 and 12..15 must not hit lane 0; only slot 5 hits.
  task automatic t_out_of_range();
    int d[8] = '{12, 13, 14, 15, 8, 0, 12, 4};
    for (int i = 0; i < 8; i++) g_dest[0][i] = d[i];
    g_tag[0] = 8'h31;
    run_batch(1);
    chk(oi.size() == 1, "R2 out-of-range codes ignored", oi.size(), 1);
  endtask

  // Hits at 1, 4, 7 with downstream stalled at first.
  task automatic t_stall();
    int exp_i[3] = '{1, 4, 7};
    for (int i = 0; i < 8; i++) g_dest[0][i] = (i == 1 || i == 4 || i == 7) ? 0 : 3;
    g_tag[0] = 8'h41;
    clear_logs();
    out_ready = 1'b0;
    push(0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R7 valid held", out_valid, 1);
      chk(out_index == 3'd1, "R7 index held", out_index, 1);
      chk(int'(out_data) == payload(8'h41, 1), "R7 data held", out_data, payload(8'h41, 1));
      chk(in_ready == 1'b0, "R6 input blocked while pending", in_ready, 0);
      @(posedge clk); #1;
    end
    out_ready = 1'b1;
    idle(6);
    chk(oi.size() == 3, "R7 nothing lost across stall", oi.size(), 3);
    for (int j = 0; j < 3 && j < oi.size(); j++) begin
      chk(oi[j] == exp_i[j], "R3 order after stall", oi[j], exp_i[j]);
      chk(od[j] == payload(8'h41, exp_i[j]), "R8 payload after stall", od[j], payload(8'h41, exp_i[j]));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    t_example();
    t_back_to_back();
    t_out_of_range();
    t_stall();
    idle(2);
    finish_run();
  end
endmodule